// File: doc/BRIEF.md
# Stereo DAC Source Routing and Gain Stage

This block sits between a stereo sample source and the data inputs of two DACs. Each time the sample strobe is high it takes a signed left and right sample. A 4-bit routing word picks what each output carries: silence, the left input, the right input, or the mean of the two. The block then scales each output by an 8-bit gain code, registers it and marks it with a one-cycle valid pulse.

A gang bit makes the right output use the left gain code in place of its own. The gang bit, the routing word and both gain codes are sampled only on a strobe cycle. Each output sample is therefore built from one consistent set of settings. A change to any of them applies from the next strobe, and no gain code has to be rewritten for it to take effect.

Top module: `stereo_route_atten`

## Requirements
- R1: While reset is asserted and after reset is released, `valid_o` is 0 and both outputs are 0 until the first strobe.
- R2: `route_i[1:0]` selects the left output source: 00 silence, 01 left input, 10 right input, 11 mean of both.
- R3: `route_i[3:2]` selects the right output source, with the same encoding as R2.
- R4: The mean is floor((left+right)/2), computed one bit wider than the data, so it never overflows: two full-scale inputs of the same sign give that full-scale value back.
- R5: A silenced output carries code 0.
- R6: Gain code 8'hFF passes the routed sample unchanged. 8'h00 gives 0. Any other code g gives floor(sample*g/256).
- R7: With `gang_att_i` at 1, the right output is scaled by `att_left_i`. With it at 0, the right output is scaled by `att_right_i`. The setting applies from the next strobe.
- R8: A strobe in cycle n gives `valid_o` high in cycle n+1 for exactly one cycle, with the new samples on the outputs in that same cycle.
- R9: Between strobes the outputs hold their value, whatever happens on the data, routing, gang or gain inputs.
- R10: Routing word 4'b1001, the reset default of the routing control, sends left to left and right to right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Input sample strobe |
| left_i | input | DATA_W | Left input sample, two's complement |
| right_i | input | DATA_W | Right input sample, two's complement |
| route_i | input | 4 | Output source selection, right in [3:2], left in [1:0] |
| gang_att_i | input | 1 | Right output uses the left gain code |
| att_left_i | input | ATT_W | Left gain code |
| att_right_i | input | ATT_W | Right gain code |
| left_o | output | DATA_W | Left DAC sample |
| right_o | output | DATA_W | Right DAC sample |
| valid_o | output | 1 | Output sample valid, one cycle per strobe |

## Verification
The bench builds the block with DATA_W=16 and the default ATT_W=8. At that width the full-scale values 32767 and -32768 can be driven directly, so the overflow-free mean can be tested at both extremes. Rounding toward minus infinity is checked on negative products and on a mean of -0.5. With 8-bit gain codes, half scale, zero and unity give known results that can be worked out by hand for each of the sixteen routing combinations.

// File: rtl/stereo_route_pkg.sv
package stereo_route_pkg;
  typedef enum logic [1:0] {
    SRC_MUTE  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_AVG   = 2'b11
  } src_sel_e;

  localparam logic [3:0] ROUTE_STRAIGHT = 4'b1001;
  localparam int unsigned N_CH = 2;
endpackage

// File: rtl/route_sel.sv
module route_sel #(
  parameter int unsigned DATA_W = 24
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic [DATA_W-1:0] data_o
);
  import stereo_route_pkg::*;

  src_sel_e          sel;
  logic [DATA_W:0]   sum;

  assign sel = src_sel_e'(sel_i);
  // one guard bit, then floor divide by two
  assign sum = {left_i[DATA_W-1], left_i} + {right_i[DATA_W-1], right_i};

  always_comb begin
    unique case (sel)
      SRC_MUTE:  data_o = '0;
      SRC_LEFT:  data_o = left_i;
      SRC_RIGHT: data_o = right_i;
      SRC_AVG:   data_o = sum[DATA_W:1];
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/att_gain.sv
module att_gain #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ATT_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [ATT_W-1:0]  att_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned PROD_W = DATA_W + ATT_W + 1;

  logic signed [PROD_W-1:0] data_ext;
  logic signed [PROD_W-1:0] att_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  assign data_ext = {{(ATT_W+1){data_i[DATA_W-1]}}, data_i};
  assign att_ext  = {{(DATA_W+1){1'b0}}, att_i};
  assign prod     = data_ext * att_ext;
  assign scaled   = prod >>> ATT_W;

  // all-ones code is exact unity
  assign data_o = (att_i == '1) ? data_i : scaled[DATA_W-1:0];
endmodule

// File: rtl/stereo_route_atten.sv
module stereo_route_atten #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ATT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [3:0]        route_i,
  input  logic              gang_att_i,
  input  logic [ATT_W-1:0]  att_left_i,
  input  logic [ATT_W-1:0]  att_right_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  import stereo_route_pkg::*;

  logic [N_CH-1:0][DATA_W-1:0] routed;
  logic [N_CH-1:0][DATA_W-1:0] scaled;
  logic [N_CH-1:0][DATA_W-1:0] out_q;
  logic [N_CH-1:0][ATT_W-1:0]  att_sel;
  logic                        valid_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    if (ch == 0) begin : g_left
      assign att_sel[ch] = att_left_i;
    end else begin : g_right
      assign att_sel[ch] = gang_att_i ? att_left_i : att_right_i;
    end

    route_sel #(.DATA_W(DATA_W)) u_route (
      .sel_i   (route_i[2*ch +: 2]),
      .left_i  (left_i),
      .right_i (right_i),
      .data_o  (routed[ch])
    );

    att_gain #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_gain (
      .data_i (routed[ch]),
      .att_i  (att_sel[ch]),
      .data_o (scaled[ch])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             out_q[ch] <= '0;
      else if (sample_valid_i) out_q[ch] <= scaled[ch];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= sample_valid_i;
  end

  assign left_o  = out_q[0];
  assign right_o = out_q[1];
  assign valid_o = valid_q;
endmodule

// File: rtl/stereo_route_atten_chk.sv
module stereo_route_atten_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ATT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic [3:0]        route_i,
  input logic              gang_att_i,
  input logic [ATT_W-1:0]  att_left_i,
  input logic [ATT_W-1:0]  att_right_i,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              valid_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (!valid_o && left_o == '0 && right_o == '0);
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> valid_o);
  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> ($stable(left_o) && $stable(right_o)));
  assert_mute_left_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && route_i[1:0] == 2'b00) |=> left_o == '0);
  assert_mute_right_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && route_i[3:2] == 2'b00) |=> right_o == '0);
  assert_zero_gain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && att_left_i == '0) |=> left_o == '0);
  assert_gang_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && gang_att_i && route_i[1:0] == route_i[3:2]) |=> left_o == right_o);
  assert_avg_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && route_i[1:0] == 2'b11 && att_left_i == '1 && left_i == right_i)
    |=> left_o == $past(left_i));
  assert_straight_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && route_i == 4'b1001 && !gang_att_i && att_left_i == '1 && att_right_i == '1)
    |=> (left_o == $past(left_i) && right_o == $past(right_i)));
endmodule

bind stereo_route_atten stereo_route_atten_chk #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .left_i         (left_i),
  .right_i        (right_i),
  .route_i        (route_i),
  .gang_att_i     (gang_att_i),
  .att_left_i     (att_left_i),
  .att_right_i    (att_right_i),
  .left_o         (left_o),
  .right_o        (right_o),
  .valid_o        (valid_o)
);

// File: tb/stereo_route_atten_tb.sv
module stereo_route_atten_tb;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sample_valid_i = 1'b0;
  logic [DW-1:0] left_i = '0;
  logic [DW-1:0] right_i = '0;
  logic [3:0]    route_i = 4'b1001;
  logic          gang_att_i = 1'b0;
  logic [AW-1:0] att_left_i = '1;
  logic [AW-1:0] att_right_i = '1;
  logic [DW-1:0] left_o;
  logic [DW-1:0] right_o;
  logic          valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  stereo_route_atten #(.DATA_W(DW), .ATT_W(AW)) u_dut (
    .clk_i, .rst_ni, .sample_valid_i, .left_i, .right_i, .route_i,
    .gang_att_i, .att_left_i, .att_right_i, .left_o, .right_o, .valid_o
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint route_model(input logic [1:0] sel, input longint l, input longint r);
    case (sel)
      2'b00:   return 0;
      2'b01:   return l;
      2'b10:   return r;
      default: return (l + r) >>> 1;
    endcase
  endfunction

  function automatic longint gain_model(input longint v, input int att);
    if (att == 255) return v;
    return (v * att) >>> 8;
  endfunction

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic run_sample(input string req, input longint l, input longint r,
                            input logic [3:0] rt, input logic gang,
                            input int al, input int ar);
    longint el, er;
    @(negedge clk_i);
    left_i = DW'(l); right_i = DW'(r); route_i = rt; gang_att_i = gang;
    att_left_i = AW'(al); att_right_i = AW'(ar);
    sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    el = gain_model(route_model(rt[1:0], l, r), al);
    er = gain_model(route_model(rt[3:2], l, r), gang ? al : ar);
    check({req, " valid"}, valid_o, 1);
    check({req, " left"}, sx(left_o), el);
    check({req, " right"}, sx(right_o), er);
  endtask

  task automatic t_reset_R1;
    check("R1 valid", valid_o, 0);
    check("R1 left", sx(left_o), 0);
    check("R1 right", sx(right_o), 0);
  endtask

  task automatic t_straight_R10;
    run_sample("R10", 1234, -567, 4'b1001, 1'b0, 255, 255);
    run_sample("R10", -32768, 32767, 4'b1001, 1'b0, 255, 255);
  endtask

  task automatic t_left_sel_R2;
    for (int s = 0; s < 4; s++)
      run_sample("R2", 300, -901, {2'b01, 2'(s)}, 1'b0, 255, 255);
  endtask

  task automatic t_right_sel_R3;
    for (int s = 0; s < 4; s++)
      run_sample("R3", -77, 5003, {2'(s), 2'b10}, 1'b0, 255, 255);
  endtask

  task automatic t_avg_R4;
    run_sample("R4", 32767, 32767, 4'b1111, 1'b0, 255, 255);
    run_sample("R4", -32768, -32768, 4'b1111, 1'b0, 255, 255);
    run_sample("R4", 3, -4, 4'b1111, 1'b0, 255, 255);
    check("R4 floor", sx(left_o), -1);
  endtask

  task automatic t_mute_R5;
    run_sample("R5", 999, -999, 4'b0000, 1'b0, 255, 255);
    check("R5 left zero", sx(left_o), 0);
  endtask

  task automatic t_gain_R6;
    run_sample("R6", 1000, -1001, 4'b1001, 1'b0, 128, 128);
    check("R6 neg floor", sx(right_o), -501);
    run_sample("R6", 1000, -1001, 4'b1001, 1'b0, 0, 255);
    run_sample("R6", -32768, 32767, 4'b1001, 1'b0, 200, 1);
  endtask

  task automatic t_gang_R7;
    run_sample("R7", 4000, 4000, 4'b1001, 1'b1, 64, 255);
    check("R7 right uses left gain", sx(right_o), 1000);
    run_sample("R7", 4000, 4000, 4'b1001, 1'b0, 64, 255);
    check("R7 right own gain", sx(right_o), 4000);
  endtask

  task automatic t_latency_R8;
    run_sample("R8", 10, 20, 4'b1001, 1'b0, 255, 255);
    @(negedge clk_i);
    check("R8 valid single cycle", valid_o, 0);
  endtask

  task automatic t_hold_R9;
    longint hl, hr;
    run_sample("R9", 111, 222, 4'b1001, 1'b0, 255, 255);
    hl = sx(left_o); hr = sx(right_o);
    @(negedge clk_i);
    left_i = 16'sd5; right_i = 16'sd6; route_i = 4'b0110; gang_att_i = 1'b1;
    att_left_i = 8'd3; att_right_i = 8'd0;
    repeat (3) @(negedge clk_i);
    check("R9 left hold", sx(left_o), hl);
    check("R9 right hold", sx(right_o), hr);
    check("R9 no valid", valid_o, 0);
  endtask

  initial begin
    #1;
    t_reset_R1();
    repeat (3) @(negedge clk_i);
    t_reset_R1();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset_R1();
    t_straight_R10();
    t_left_sel_R2();
    t_right_sel_R3();
    t_avg_R4();
    t_mute_R5();
    t_gain_R6();
    t_gang_R7();
    t_latency_R8();
    t_hold_R9();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule